// File: doc/BRIEF.md
# Normalizing Binary Long Divider

This block is a sequential unsigned divider for wide operands. It uses shift-and-subtract steps only and needs no multiplier. A single-cycle start pulse captures a dividend and a divisor. The block then finds how many significant bits each operand carries. It lines the divisor up under the dividend's leading one and walks the divisor back down one bit position per cycle. The run ends with a single-cycle done pulse that presents the quotient, the remainder and a divide-by-zero flag.

The number of iterations follows the difference in significant-bit counts, not the full operand width. Short divisions of wide numbers therefore finish in a few cycles. An iteration that leaves the running remainder at exactly zero ends the run at once, because every lower quotient bit would be zero. A zero divisor skips the iterations completely.

Top module: `nrm_divider`

## Requirements
- R1: For a nonzero divisor, the outputs at the done pulse satisfy dividend = quotient * divisor + remainder, with remainder < divisor.
- R2: For a zero divisor, the done pulse comes 2 cycles after the start edge, with the zero flag at 1, the quotient all ones and the remainder equal to the dividend. For a nonzero divisor the zero flag is 0.
- R3: Busy goes high at the clock edge that accepts a start, stays high until the edge that raises done, and is low while done is high.
- R4: Done is high for exactly one cycle per accepted operation.
- R5: A start pulse that arrives while busy is high has no effect: the running operation completes with the operands it accepted.
- R6: Let len(v) be the count of significant bits of v, with len(0) = 0, and let s = max(len(dividend) − len(divisor), 0). For a nonzero divisor whose remainder is nonzero, done comes s + 3 cycles after the start edge.
- R7: When the remainder is zero, done comes no later than s + 3 cycles after the start edge. When the dividend equals the divisor shifted left by any amount k ≥ 0, done comes exactly 3 cycles after the start edge.
- R8: After reset, busy and done are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a division; accepted only while busy is low |
| dividend_i | input | W | Unsigned dividend, sampled with start |
| divisor_i | input | W | Unsigned divisor, sampled with start |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse: results valid |
| quotient_o | output | W | Quotient, valid at done |
| remainder_o | output | W | Remainder, valid at done |
| div_zero_o | output | 1 | Divisor was zero, valid at done |

## Verification
The bench sweeps every dividend and divisor pair of a 6-bit configuration. A wrong shift clamp, for example one that wraps when the divisor is longer than the dividend, shows up as a wrong quotient or as an outsized latency. The bench predicts the cycle count exactly from the significant-bit lengths. A missing equality exit therefore shows up as the slower s + 3 latency on exact power-of-two multiples. A loop that does not stop at a zero count shows up as extra cycles or as corrupted low quotient bits. The bench also fires a start pulse in the middle of a long run, so a design that restarted on it would return a result for the wrong operands. Zero divisors, including a zero dividend, check the all-ones quotient and the pass-through remainder.

// File: rtl/nrm_div_pkg.sv
package nrm_div_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_NORM,
      ST_STEP,
      ST_ZERO
   } div_state_e;

   typedef enum logic [1:0] {
      REL_LT,
      REL_EQ,
      REL_GT
   } rel_e;

endpackage

// File: rtl/nrm_lod.sv
module nrm_lod #(
   parameter int W  = 128,
   parameter int LW = $clog2(W + 1)
) (
   input  logic [W-1:0]  val_i,
   output logic [LW-1:0] len_o
);
   // Significant-bit length: index of the highest set bit plus one, 0 for zero.
   always_comb begin
      len_o = '0;
      for (int i = 0; i < W; i++) begin
         if (val_i[i]) len_o = LW'(i + 1);
      end
   end
endmodule

// File: rtl/nrm_align.sv
module nrm_align #(
   parameter int W  = 128,
   parameter int LW = $clog2(W + 1)
) (
   input  logic [LW-1:0] len_num_i,
   input  logic [LW-1:0] len_den_i,
   input  logic [W-1:0]  den_i,
   output logic [LW-1:0] shift_o,
   output logic [W-1:0]  den_aligned_o,
   output logic [W-1:0]  bit_aligned_o
);
   localparam logic [W-1:0] ONE = W'(1);

   always_comb begin
      // Clamp a negative length difference to zero.
      if (len_num_i > len_den_i) shift_o = len_num_i - len_den_i;
      else                       shift_o = '0;
      den_aligned_o = den_i << shift_o;
      bit_aligned_o = ONE << shift_o;
   end
endmodule

// File: rtl/nrm_cmp3.sv
module nrm_cmp3
   import nrm_div_pkg::*;
#(
   parameter int W          = 128,
   parameter bit SHARED_SUB = 1'b1
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output rel_e         rel_o,
   output logic [W-1:0] diff_o
);
   generate
      if (SHARED_SUB) begin : g_shared
         // One subtractor produces both the ordering and the difference.
         logic borrow;
         always_comb begin
            {borrow, diff_o} = {1'b0, a_i} - {1'b0, b_i};
            if (borrow)            rel_o = REL_LT;
            else if (diff_o == '0) rel_o = REL_EQ;
            else                   rel_o = REL_GT;
         end
      end else begin : g_split
         // Separate magnitude comparator beside the subtractor.
         always_comb begin
            diff_o = a_i - b_i;
            if (a_i < b_i)       rel_o = REL_LT;
            else if (a_i == b_i) rel_o = REL_EQ;
            else                 rel_o = REL_GT;
         end
      end
   endgenerate
endmodule

// File: rtl/nrm_divider.sv
module nrm_divider
   import nrm_div_pkg::*;
#(
   parameter int W          = 128,
   parameter bit SHARED_SUB = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic [W-1:0] dividend_i,
   input  logic [W-1:0] divisor_i,
   output logic         busy_o,
   output logic         done_o,
   output logic [W-1:0] quotient_o,
   output logic [W-1:0] remainder_o,
   output logic         div_zero_o
);
   localparam int LW = $clog2(W + 1);

   generate
      if (W < 2) begin : g_bad_width
         $error("nrm_divider: W must be at least 2");
      end
   endgenerate

   div_state_e    state_q;
   logic [W-1:0]  rem_q, den_q, bit_q, quo_q;
   logic [LW-1:0] cnt_q;
   logic          done_q, zero_q;

   logic [LW-1:0] len_num, len_den, shift;
   logic [W-1:0]  den_al, bit_al, diff;
   rel_e          rel;

   nrm_lod #(.W(W), .LW(LW)) u_lod_num (.val_i(rem_q), .len_o(len_num));
   nrm_lod #(.W(W), .LW(LW)) u_lod_den (.val_i(den_q), .len_o(len_den));

   nrm_align #(.W(W), .LW(LW)) u_align (
      .len_num_i    (len_num),
      .len_den_i    (len_den),
      .den_i        (den_q),
      .shift_o      (shift),
      .den_aligned_o(den_al),
      .bit_aligned_o(bit_al)
   );

   nrm_cmp3 #(.W(W), .SHARED_SUB(SHARED_SUB)) u_cmp (
      .a_i   (rem_q),
      .b_i   (den_q),
      .rel_o (rel),
      .diff_o(diff)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         rem_q   <= '0;
         den_q   <= '0;
         bit_q   <= '0;
         quo_q   <= '0;
         cnt_q   <= '0;
         done_q  <= 1'b0;
         zero_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  rem_q   <= dividend_i;
                  den_q   <= divisor_i;
                  zero_q  <= 1'b0;
                  state_q <= (divisor_i == '0) ? ST_ZERO : ST_NORM;
               end
            end
            ST_NORM: begin
               den_q   <= den_al;
               bit_q   <= bit_al;
               quo_q   <= '0;
               cnt_q   <= shift;
               state_q <= ST_STEP;
            end
            ST_STEP: begin
               if (rel != REL_LT) begin
                  quo_q <= quo_q | bit_q;
                  rem_q <= diff;
               end
               if (rel == REL_EQ || cnt_q == '0) begin
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end else begin
                  den_q <= den_q >> 1;
                  bit_q <= bit_q >> 1;
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            ST_ZERO: begin
               quo_q   <= '1;
               zero_q  <= 1'b1;
               done_q  <= 1'b1;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o      = (state_q != ST_IDLE);
   assign done_o      = done_q;
   assign quotient_o  = quo_q;
   assign remainder_o = rem_q;
   assign div_zero_o  = zero_q;

endmodule

// File: rtl/nrm_divider_chk.sv
module nrm_divider_chk #(
   parameter int W = 128
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start_i,
   input logic [W-1:0] dividend_i,
   input logic [W-1:0] divisor_i,
   input logic         busy_o,
   input logic         done_o,
   input logic [W-1:0] quotient_o,
   input logic [W-1:0] remainder_o,
   input logic         div_zero_o
);
   localparam int CW = $clog2(W + 1) + 2;

   logic [W-1:0]   dvd_q, dvs_q;
   logic [CW-1:0]  lat_q;
   logic [2*W-1:0] recon;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dvd_q <= '0;
         dvs_q <= '0;
         lat_q <= '0;
      end else if (start_i && !busy_o) begin
         dvd_q <= dividend_i;
         dvs_q <= divisor_i;
         lat_q <= CW'(1);
      end else if (busy_o) begin
         lat_q <= lat_q + 1'b1;
      end
   end

   assign recon = ({{W{1'b0}}, quotient_o} * {{W{1'b0}}, dvs_q}) + {{W{1'b0}}, remainder_o};

   p_div_identity_r1: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && dvs_q != '0 |-> recon == {{W{1'b0}}, dvd_q} && remainder_o < dvs_q);

   p_zero_div_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && dvs_q == '0 |-> div_zero_o && quotient_o == '1 && remainder_o == dvd_q);

   p_no_zero_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && dvs_q != '0 |-> !div_zero_o);

   p_busy_on_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && !busy_o |=> busy_o);

   p_idle_at_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   p_done_from_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> $past(busy_o));

   p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_latency_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> lat_q <= CW'(W + 2));

endmodule

bind nrm_divider nrm_divider_chk #(.W(W)) i_nrm_divider_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .dividend_i (dividend_i),
   .divisor_i  (divisor_i),
   .busy_o     (busy_o),
   .done_o     (done_o),
   .quotient_o (quotient_o),
   .remainder_o(remainder_o),
   .div_zero_o (div_zero_o)
);

// File: tb/test_nrm_divider.sv
`timescale 1ns/1ps
module test_nrm_divider;
   localparam int W   = 6;
   localparam int MAX = 1 << W;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_i = 1'b0;
   logic [W-1:0] dividend_i = '0;
   logic [W-1:0] divisor_i = '0;
   logic         busy_o, done_o, div_zero_o;
   logic [W-1:0] quotient_o, remainder_o;

   int n_checks = 0;
   int n_errors = 0;

   always #2 clk = ~clk;

   nrm_divider #(.W(W)) i_nrm_divider (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .dividend_i (dividend_i),
      .divisor_i  (divisor_i),
      .busy_o     (busy_o),
      .done_o     (done_o),
      .quotient_o (quotient_o),
      .remainder_o(remainder_o),
      .div_zero_o (div_zero_o)
   );

   function automatic int bitlen(int v);
      int n = 0;
      while (v > 0) begin
         n++;
         v = v >> 1;
      end
      return n;
   endfunction

   function automatic bit is_pow2_multiple(int a, int b);
      for (int k = 0; k < W; k++) begin
         if ((b << k) == a) return 1'b1;
      end
      return 1'b0;
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Runs one division; optionally fires a stray start mid-run (R5).
   task automatic run(int a, int b, bit stray);
      int  lat;
      int  shift;
      bit  busy_ok;
      @(negedge clk);
      dividend_i = W'(a);
      divisor_i  = W'(b);
      start_i    = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      lat     = 1;
      busy_ok = 1'b1;
      while (!done_o && lat < 60) begin
         if (!busy_o) busy_ok = 1'b0;
         if (stray && lat == 2) begin
            start_i    = 1'b1;
            dividend_i = W'(a ^ 21);
            divisor_i  = W'(1);
         end else begin
            start_i = 1'b0;
         end
         @(negedge clk);
         lat++;
      end
      start_i = 1'b0;
      check(done_o, "R4 done seen", int'(done_o), 1);
      check(busy_ok && !busy_o, "R3 busy span", int'(busy_o), 0);
      shift = bitlen(a) - bitlen(b);
      if (shift < 0) shift = 0;
      if (b == 0) begin
         check(div_zero_o && quotient_o == '1 && int'(remainder_o) == a,
               "R2 zero divisor result", int'(remainder_o), a);
         check(lat == 2, "R2 zero divisor latency", lat, 2);
      end else begin
         check(int'(quotient_o) == a / b, stray ? "R5 quotient" : "R1 quotient",
               int'(quotient_o), a / b);
         check(int'(remainder_o) == a % b, stray ? "R5 remainder" : "R1 remainder",
               int'(remainder_o), a % b);
         check(!div_zero_o, "R2 flag clear", int'(div_zero_o), 0);
         if (a % b != 0)                 check(lat == shift + 3, "R6 latency", lat, shift + 3);
         else if (is_pow2_multiple(a, b)) check(lat == 3, "R7 early exit latency", lat, 3);
         else                             check(lat <= shift + 3, "R7 latency bound", lat, shift + 3);
      end
      @(negedge clk);
      check(!done_o, "R4 single pulse", int'(done_o), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(!busy_o && !done_o, "R8 reset state", int'(busy_o) + int'(done_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy_o && !done_o, "R8 idle after reset", int'(busy_o) + int'(done_o), 0);

      for (int a = 0; a < MAX; a++) begin
         for (int b = 0; b < MAX; b++) begin
            run(a, b, 1'b0);
         end
      end

      // R5: stray start pulses during long runs
      run(63, 1, 1'b1);
      run(62, 3, 1'b1);
      run(40, 0, 1'b1);

      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      #(4 * 200000);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule